// File: doc/BRIEF.md
# Tag Strobe Timing Generator

This block times a single command transfer to a disk drive across a tag bus. A requesting sequencer pulses a start input. The block then runs a small cycle counter and decodes the counter value into three outputs. The tag strobe is a window that opens a fixed number of cycles after the start. Count-off warns other logic one cycle before that window closes. Done is a single-cycle pulse sent back to the sequencer after a short gap. The tag data itself is held in a register outside this block.

After done the block goes idle and waits for the next start. A start that arrives during a run has no effect. Every decode point is a parameter, so the same block can drive tag buses with other setup and hold needs. The counter width sets the range of values that can be decoded.

Top module: `tag_strobe_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset is released, tag_strobe_o, count_off_o and done_o are all 0 and the block is idle.
- R2: If start_i is high at a rising clock edge while the block is idle, a run begins. The internal count is 0 in the cycle after that edge and rises by one on every later edge. The offset of a cycle is its distance from that first cycle, so the first cycle is offset 0.
- R3: tag_strobe_o is 1 exactly at offsets STROBE_LO through STROBE_HI inclusive. With the defaults this is offsets 3 to 13, which is 11 cycles.
- R4: count_off_o is 1 only at offset CNTOFF_AT, which is 12 by default. That is one cycle before the strobe window ends.
- R5: done_o is 1 only at offset DONE_AT, which is 15 by default, and tag_strobe_o is 0 in that cycle.
- R6: The block leaves the run on the edge that ends the done cycle. From then on all three outputs stay 0 until a new run begins.
- R7: A start_i that is high during a run, including in the done cycle, is ignored. The run keeps its original timing, and no new run follows if start_i is high in the done cycle only.
- R8: A start_i in any idle cycle after a run, including the first one, begins a new run with the same timing as in R2 to R6.
- R9: Driving rst_ni low during a run forces all outputs to 0 at once, without waiting for a clock edge, and returns the block to idle.
- R10: DONE_AT may be set as high as the largest value the counter can hold, which is 2**CNT_W-1. The run then ends without the counter wrapping around, and R3 to R6 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| tag_strobe_o | output | 1 | Tag strobe window |
| count_off_o | output | 1 | Warns that the strobe window is about to close |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block. One uses the default setting: a 5-bit counter, strobe at offsets 3 to 13, count-off at 12 and done at 15. In this copy it checks ignored starts, a start in the done cycle, a restart from idle, and a reset in the middle of a run. The second copy moves done to 31 and the strobe window to 3 to 29, with count-off at 28. This drives the counter to its top value, which shows that the end of the run is decoded there and the counter never wraps.

// File: rtl/tsg_pkg.sv
`timescale 1ns/1ps
package tsg_pkg;
  localparam int unsigned TSG_CNT_W = 5;

  typedef struct packed {
    logic strobe;
    logic cntoff;
    logic done;
  } tsg_flags_t;
endpackage

// File: rtl/tsg_counter.sv
`timescale 1ns/1ps
module tsg_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (end_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/tsg_decode.sv
`timescale 1ns/1ps
module tsg_decode
  import tsg_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned STROBE_LO = 3,
  parameter int unsigned STROBE_HI = 13,
  parameter int unsigned CNTOFF_AT = 12,
  parameter int unsigned DONE_AT   = 15
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             busy_i,
  output tsg_flags_t       flags_o
);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(STROBE_LO);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(STROBE_HI);
  localparam logic [CNT_W-1:0] CO_C  = CNT_W'(CNTOFF_AT);
  localparam logic [CNT_W-1:0] END_C = CNT_W'(DONE_AT);
  localparam int unsigned      MAX_V = (1 << CNT_W) - 1;

  logic lo_ok, hi_ok;

  // skip compares that are always true, keeps the window a plain range
  generate
    if (STROBE_LO == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (cnt_i >= LO_C);
    end
    if (STROBE_HI >= MAX_V) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (cnt_i <= HI_C);
    end
  endgenerate

  always_comb begin
    flags_o.strobe = busy_i && lo_ok && hi_ok;
    flags_o.cntoff = busy_i && (cnt_i == CO_C);
    flags_o.done   = busy_i && (cnt_i == END_C);
  end
endmodule

// File: rtl/tag_strobe_gen.sv
`timescale 1ns/1ps
module tag_strobe_gen
  import tsg_pkg::*;
#(
  parameter int unsigned CNT_W     = TSG_CNT_W,
  parameter int unsigned STROBE_LO = 3,
  parameter int unsigned STROBE_HI = 13,
  parameter int unsigned CNTOFF_AT = 12,
  parameter int unsigned DONE_AT   = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic tag_strobe_o,
  output logic count_off_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(STROBE_LO);

  logic [CNT_W-1:0] cnt;
  logic             busy;
  tsg_flags_t       flags;

  tsg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .end_i  (flags.done),
    .cnt_o  (cnt),
    .busy_o (busy)
  );

  tsg_decode #(
    .CNT_W    (CNT_W),
    .STROBE_LO(STROBE_LO),
    .STROBE_HI(STROBE_HI),
    .CNTOFF_AT(CNTOFF_AT),
    .DONE_AT  (DONE_AT)
  ) u_dec (
    .cnt_i  (cnt),
    .busy_i (busy),
    .flags_o(flags)
  );

  assign tag_strobe_o = flags.strobe;
  assign count_off_o  = flags.cntoff;
  assign done_o       = flags.done;

  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && start_i |=> busy && cnt == '0);

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_o |=> busy && cnt == CNT_W'($past(cnt) + 1'b1));

  a_r3_strobe_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_strobe_o) |-> cnt == LO_C);

  a_r4_cntoff_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_off_o |-> tag_strobe_o);

  a_r5_done_strobe_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tag_strobe_o);

  a_r6_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy && !done_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !(tag_strobe_o || count_off_o || done_o));

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_o && start_i |=> cnt != '0);
endmodule

// File: tb/tb_tag_strobe_gen.sv
`timescale 1ns/1ps
module tb_tag_strobe_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_a = 1'b0;
  logic start_b = 1'b0;
  logic str_a, co_a, dn_a, str_b, co_b, dn_b;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tag_strobe_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_a),
    .tag_strobe_o(str_a), .count_off_o(co_a), .done_o(dn_a)
  );

  tag_strobe_gen #(.STROBE_HI(29), .CNTOFF_AT(28), .DONE_AT(31)) dut2 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b),
    .tag_strobe_o(str_b), .count_off_o(co_b), .done_o(dn_b)
  );

  // {start driven after sample, expected {strobe,cntoff,done}}
  typedef struct packed { logic st; logic [2:0] ex; } vec_t;
  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'b000},  // idle, launch
    '{1'b0, 3'b000},  // off0
    '{1'b1, 3'b000},  // off1, start ignored
    '{1'b0, 3'b000},  // off2
    '{1'b1, 3'b100},  // off3
    '{1'b0, 3'b100}, '{1'b0, 3'b100}, '{1'b0, 3'b100}, '{1'b0, 3'b100},
    '{1'b0, 3'b100}, '{1'b0, 3'b100}, '{1'b0, 3'b100}, '{1'b0, 3'b100},  // off4..11
    '{1'b0, 3'b110},  // off12
    '{1'b0, 3'b100},  // off13
    '{1'b0, 3'b000},  // off14
    '{1'b1, 3'b001},  // off15 done, start ignored
    '{1'b0, 3'b000},  // off16 idle, no run from done-cycle start
    '{1'b1, 3'b000},  // off17 idle, relaunch
    '{1'b0, 3'b000},  // off0
    '{1'b0, 3'b000},  // off1
    '{1'b0, 3'b000},  // off2
    '{1'b0, 3'b100}   // off3
  };

  function automatic logic [2:0] exp_at(int off, int lo, int hi, int co, int dn);
    if (off < 0 || off > dn) return 3'b000;
    return {(off >= lo && off <= hi), (off == co), (off == dn)};
  endfunction

  task automatic chk(string rq, logic [2:0] got, logic [2:0] ex);
    total++;
    if (got !== ex) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b at %0t", rq, got, ex, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] ex);
    if (ex[0]) return "R5";
    if (ex[1]) return "R4";
    if (ex[2]) return "R3";
    return "R2";
  endfunction

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1", {str_a, co_a, dn_a}, 3'b000);
    chk("R1", {str_b, co_b, dn_b}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {str_a, co_a, dn_a}, 3'b000);

    // table walk: R2..R8 on default build
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk(i == 17 ? "R7" : (i == 18 ? "R8" : tag_of(TBL[i].ex)),
          {str_a, co_a, dn_a}, TBL[i].ex);
      start_a = TBL[i].st;
    end
    for (int off = 4; off <= 20; off++) begin
      @(negedge clk);
      chk(off > 15 ? "R6" : "R8", {str_a, co_a, dn_a}, exp_at(off, 3, 13, 12, 15));
    end

    // R9 reset mid-run
    start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", {str_a, co_a, dn_a}, 3'b100);
    #1 rst_ni = 1'b0;
    #1 chk("R9", {str_a, co_a, dn_a}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9", {str_a, co_a, dn_a}, 3'b000);
    end

    // R10 done at counter maximum
    start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    for (int off = 0; off <= 35; off++) begin
      chk("R10", {str_b, co_b, dn_b}, exp_at(off, 3, 29, 28, 31));
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule